// File: doc/BRIEF.md
# Software-Managed TLB Entry Store

This block holds the translation entries of a small, fully associative TLB that is filled and inspected by software. Each of the sixteen entries maps a pair of neighbouring virtual pages: one even page and one odd page. Each half has its own frame number, valid bit, dirty bit and cache attribute. The pair shares one virtual page tag, one address-space identifier, one page-size field and a global bit. Software places values in a set of staging words: a high word with the page tag and identifier, an even-page low word, an odd-page low word, a page-size word and an index word. It then fires one of four strobes.

The four commands are as follows. Indexed write stores the staging words into the entry named by the index word. Random write stores them into the entry named by an externally generated random selector. Probe searches all entries for the tag and identifier held in the high word. Read copies one entry back into the staging words. One clock after any strobe, the block presents the updated staging words and raises `done` for a single cycle. The host then copies those words back into its own staging registers.

Top module: `tlb16_mgr`

## Requirements
- R1: While reset is low and on the first cycle after it, `done` is 0 and every `up_*` output is 0. Every entry is cleared to all-zero fields, so reading any entry after reset returns zeros in all four words.
- R2: `done` is 1 in exactly the cycle after a cycle with at least one strobe high. It is 0 after a cycle with no strobe. The `up_*` outputs change only together with `done`.
- R3: An indexed write targets the entry given by `st_index[3:0]`. The other index bits do not select the entry.
- R4: A random write targets the entry given by `rand_sel` and leaves the entry named by `st_index` untouched.
- R5: The global bit of an entry is `st_lo_even[0] AND st_lo_odd[0]` at write time. A read returns that global bit in bit 0 of both `up_lo_even` and `up_lo_odd`.
- R6: A read returns the following values from the entry named by `st_index[3:0]`. `up_hi` holds the stored tag in bits 31:13, zeros in bits 12:8 and the identifier in bits 7:0. Bits 31:1 of each low word (frame number 31:6, cache attribute 5:3, dirty 2, valid 1) equal the written values.
- R7: A write stores page-size bits 24:13 of `st_pmask`. A read returns them in the same positions with all other bits of `up_pmask` zero.
- R8: A probe hits an entry when its tag equals `st_hi[31:13]` and either its global bit is set or its identifier equals `st_hi[7:0]`. On a hit, `up_index` is the entry number with bits 31:4 zero.
- R9: When several entries hit, the probe returns the lowest entry number.
- R10: On a probe miss, `up_index` is `st_index` with bit 31 forced to 1 and bits 30:0 unchanged.
- R11: On any command, each `up_*` word that the command does not produce echoes its staging input. A write echoes all five words, a probe echoes all but the index, and a read echoes the index.
- R12: When several strobes are high together, only one command runs, chosen in the order indexed write, random write, probe, read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_idx_go | input | 1 | Indexed-write strobe |
| wr_rand_go | input | 1 | Random-write strobe |
| probe_go | input | 1 | Probe strobe |
| read_go | input | 1 | Read strobe |
| rand_sel | input | 4 | Entry used by a random write |
| st_hi | input | 32 | Staging high word: tag 31:13, identifier 7:0 |
| st_lo_even | input | 32 | Staging even-page low word |
| st_lo_odd | input | 32 | Staging odd-page low word |
| st_pmask | input | 32 | Staging page-size word, field 24:13 |
| st_index | input | 32 | Staging index word, entry in 3:0 |
| done | output | 1 | One-cycle pulse, command complete |
| up_hi | output | 32 | Updated high word |
| up_lo_even | output | 32 | Updated even-page low word |
| up_lo_odd | output | 32 | Updated odd-page low word |
| up_pmask | output | 32 | Updated page-size word |
| up_index | output | 32 | Updated index word, bit 31 = probe miss |

## Verification
The entry store is only visible through reads and probes, so a corrupted field stays hidden until software touches that entry. A bad tag, identifier or half-word shows in the words returned by the next read of that slot, one cycle after the read strobe. A wrong global bit or a wrong priority in the match logic shows as a wrong entry number or a spurious miss bit in the index, one cycle after the probe strobe. The bench therefore writes distinct patterns into several slots, reads each one back, and probes for identifier mismatches, global overrides and duplicate tags.

// File: rtl/tlb16_mgr.sv
module tlb16_mgr #(
  parameter int ENTRIES = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_idx_go,
  input  logic                       wr_rand_go,
  input  logic                       probe_go,
  input  logic                       read_go,
  input  logic [$clog2(ENTRIES)-1:0] rand_sel,
  input  logic [31:0]                st_hi,
  input  logic [31:0]                st_lo_even,
  input  logic [31:0]                st_lo_odd,
  input  logic [31:0]                st_pmask,
  input  logic [31:0]                st_index,
  output logic                       done,
  output logic [31:0]                up_hi,
  output logic [31:0]                up_lo_even,
  output logic [31:0]                up_lo_odd,
  output logic [31:0]                up_pmask,
  output logic [31:0]                up_index
);
  localparam int IW = $clog2(ENTRIES);

  logic [18:0] tag_q  [ENTRIES];
  logic [7:0]  id_q   [ENTRIES];
  logic [11:0] size_q [ENTRIES];
  logic        glb_q  [ENTRIES];
  logic [30:0] even_q [ENTRIES];
  logic [30:0] odd_q  [ENTRIES];

  wire go_wi = wr_idx_go;
  wire go_wr = wr_rand_go & ~wr_idx_go;
  wire go_pr = probe_go & ~wr_idx_go & ~wr_rand_go;
  wire go_rd = read_go & ~wr_idx_go & ~wr_rand_go & ~probe_go;
  wire any_go = wr_idx_go | wr_rand_go | probe_go | read_go;

  wire [IW-1:0] wsel = go_wi ? st_index[IW-1:0] : rand_sel;
  wire [IW-1:0] rsel = st_index[IW-1:0];

  logic          hit;
  logic [IW-1:0] hit_idx;

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (tag_q[i] == st_hi[31:13] && (glb_q[i] || id_q[i] == st_hi[7:0])) begin
        hit = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end

  wire [31:0] probe_idx = hit ? {{(32-IW){1'b0}}, hit_idx} : {1'b1, st_index[30:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]  <= '0;
        id_q[i]   <= '0;
        size_q[i] <= '0;
        glb_q[i]  <= 1'b0;
        even_q[i] <= '0;
        odd_q[i]  <= '0;
      end
      done       <= 1'b0;
      up_hi      <= '0;
      up_lo_even <= '0;
      up_lo_odd  <= '0;
      up_pmask   <= '0;
      up_index   <= '0;
    end else begin
      done <= any_go;
      if (go_wi || go_wr) begin
        tag_q[wsel]  <= st_hi[31:13];
        id_q[wsel]   <= st_hi[7:0];
        size_q[wsel] <= st_pmask[24:13];
        glb_q[wsel]  <= st_lo_even[0] & st_lo_odd[0];
        even_q[wsel] <= st_lo_even[31:1];
        odd_q[wsel]  <= st_lo_odd[31:1];
      end
      if (any_go) begin
        up_hi      <= go_rd ? {tag_q[rsel], 5'b0, id_q[rsel]} : st_hi;
        up_lo_even <= go_rd ? {even_q[rsel], glb_q[rsel]} : st_lo_even;
        up_lo_odd  <= go_rd ? {odd_q[rsel], glb_q[rsel]} : st_lo_odd;
        up_pmask   <= go_rd ? {7'b0, size_q[rsel], 13'b0} : st_pmask;
        up_index   <= go_pr ? probe_idx : st_index;
      end
    end
  end

  // R2
  done_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_go |=> done);

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_go |=> !done);

  // R2
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_go |=> $stable(up_index) && $stable(up_hi));

  // R10
  miss_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_pr |=> !up_index[31] || up_index[30:0] == $past(st_index[30:0]));

  // R8
  hit_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_pr |=> up_index[31] || up_index[31:IW] == '0);

  // R5
  read_global_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_rd |=> up_lo_even[0] == up_lo_odd[0]);

  // R7
  read_size_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_rd |=> up_pmask[31:25] == '0 && up_pmask[12:0] == '0);
endmodule

// File: tb/tlb16_mgr_bench.sv
`timescale 1ns/1ps
module tlb16_mgr_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wi = 1'b0, wr = 1'b0, pr = 1'b0, rd = 1'b0;
  logic [3:0] rsel = '0;
  logic [31:0] hi = '0, le = '0, lo = '0, pm = '0, ix = '0;
  logic done;
  logic [31:0] o_hi, o_le, o_lo, o_pm, o_ix;

  always #2.5 clk = ~clk;

  tlb16_mgr u_tlb16_mgr (
    .clk(clk), .rst_n(rst_n),
    .wr_idx_go(wi), .wr_rand_go(wr), .probe_go(pr), .read_go(rd),
    .rand_sel(rsel), .st_hi(hi), .st_lo_even(le), .st_lo_odd(lo),
    .st_pmask(pm), .st_index(ix),
    .done(done), .up_hi(o_hi), .up_lo_even(o_le), .up_lo_odd(o_lo),
    .up_pmask(o_pm), .up_index(o_ix)
  );

  typedef struct {
    logic [31:0] hi, le, lo, pm, ix;
    string req;
  } exp_t;

  exp_t sb[$];
  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  logic [31:0] m_hi [16];
  logic [31:0] m_le [16];
  logic [31:0] m_lo [16];
  logic [31:0] m_pm [16];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      vectors++;
      if (sb.size() == 0) begin
        miscompares++;
        $display("FAIL R2 done actual=1 expected=0 (no command pending)");
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.req, "hi", o_hi, e.hi);
        chk(e.req, "lo_even", o_le, e.le);
        chk(e.req, "lo_odd", o_lo, e.lo);
        chk(e.req, "pmask", o_pm, e.pm);
        chk(e.req, "index", o_ix, e.ix);
      end
    end
  end

  task automatic cmd(input bit a_wi, input bit a_wr, input bit a_pr, input bit a_rd,
                     input logic [31:0] a_hi, input logic [31:0] a_le, input logic [31:0] a_lo,
                     input logic [31:0] a_pm, input logic [31:0] a_ix, input logic [3:0] a_rs,
                     input string req);
    exp_t e;
    bit ewi, ewr, epr, erd;
    logic [3:0] s;
    logic g;
    ewi = a_wi;
    ewr = a_wr && !a_wi;
    epr = a_pr && !a_wi && !a_wr;
    erd = a_rd && !a_wi && !a_wr && !a_pr;
    e.hi = a_hi; e.le = a_le; e.lo = a_lo; e.pm = a_pm; e.ix = a_ix; e.req = req;
    if (epr) begin
      e.ix = a_ix | 32'h8000_0000;
      for (int i = 15; i >= 0; i--) begin
        g = m_le[i][0] & m_lo[i][0];
        if (m_hi[i][31:13] == a_hi[31:13] && (g || m_hi[i][7:0] == a_hi[7:0]))
          e.ix = i;
      end
    end
    if (erd) begin
      s = a_ix[3:0];
      g = m_le[s][0] & m_lo[s][0];
      e.hi = m_hi[s];
      e.le = {m_le[s][31:1], g};
      e.lo = {m_lo[s][31:1], g};
      e.pm = m_pm[s];
    end
    if (ewi || ewr) begin
      s = ewi ? a_ix[3:0] : a_rs;
      m_hi[s] = a_hi & 32'hFFFF_E0FF;
      m_le[s] = a_le;
      m_lo[s] = a_lo;
      m_pm[s] = a_pm & 32'h01FF_E000;
    end
    @(negedge clk);
    wi = a_wi; wr = a_wr; pr = a_pr; rd = a_rd;
    hi = a_hi; le = a_le; lo = a_lo; pm = a_pm; ix = a_ix; rsel = a_rs;
    sb.push_back(e);
    @(negedge clk);
    wi = 0; wr = 0; pr = 0; rd = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_hi[i] = '0; m_le[i] = '0; m_lo[i] = '0; m_pm[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    vectors++;
    chk("R1", "done", {31'b0, done}, 32'h0);
    chk("R1", "hi", o_hi, 32'h0);
    chk("R1", "index", o_ix, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    vectors++;
    chk("R1", "pmask", o_pm, 32'h0);
    chk("R1", "lo_even", o_le, 32'h0);

    // R1 cleared entry reads zero
    cmd(0,0,0,1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0005, 4'h0, "R1");
    // R3 R11 indexed write, upper index bits ignored
    cmd(1,0,0,0, 32'h1234_5F7A, 32'hDEAD_BEEF, 32'h0000_1002, 32'hFFFF_FFFF, 32'hABC0_0013, 4'h7, "R3/R11");
    // R6 R7 R5 read back, g=0
    cmd(0,0,0,1, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_0003, 4'h0, "R6/R7/R5");
    // R4 random write to 9, index names 3
    cmd(0,1,0,0, 32'h0040_2011, 32'h0000_0041, 32'h0000_0083, 32'h0000_6000, 32'h0000_0003, 4'h9, "R4");
    cmd(0,0,0,1, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_0009, 4'h0, "R4/R5");
    cmd(0,0,0,1, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_0003, 4'h0, "R4");
    // R10 identifier mismatch, not global
    cmd(0,0,1,0, 32'h1234_4099, 32'h5, 32'h6, 32'h7, 32'h0000_0005, 4'h0, "R10");
    cmd(0,0,1,0, 32'h7777_E000, 32'h0, 32'h0, 32'h0, 32'h0000_00F0, 4'h0, "R10");
    // R8 global override and exact match
    cmd(0,0,1,0, 32'h0040_20FF, 32'h0, 32'h0, 32'h0, 32'h8000_0000, 4'h0, "R8");
    cmd(0,0,1,0, 32'h1234_407A, 32'h0, 32'h0, 32'h0, 32'h8000_000A, 4'h0, "R8");
    // R9 duplicates in 12 and 6
    cmd(1,0,0,0, 32'h7000_0055, 32'h0000_0102, 32'h0, 32'h0, 32'h0000_000C, 4'h0, "R9");
    cmd(1,0,0,0, 32'h7000_0055, 32'h0000_0202, 32'h0, 32'h0, 32'h0000_0006, 4'h0, "R9");
    cmd(0,0,1,0, 32'h7000_0055, 32'h0, 32'h0, 32'h0, 32'h0000_0000, 4'h0, "R9");
    // R12 write beats read, random write beats probe
    cmd(1,0,0,1, 32'hCAFE_2033, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0155_4000, 32'h0000_000E, 4'h2, "R12");
    cmd(0,0,0,1, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_000E, 4'h0, "R12/R5");
    cmd(0,1,1,1, 32'h0808_0044, 32'h0000_00C4, 32'h0000_0005, 32'h0, 32'h0000_0004, 4'h1, "R12");
    cmd(0,0,0,1, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_0001, 4'h0, "R12");
    cmd(0,0,0,1, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_0004, 4'h0, "R12");

    repeat (3) @(negedge clk);
    vectors++;
    if (sb.size() != 0) begin
      miscompares++;
      $display("FAIL R2 pending actual=%0d expected=0", sb.size());
    end
    finish_run();
  end
endmodule